// File: doc/BRIEF.md
# Auto-Increment Packet Access Port

This block lets a host move bytes and 16-bit words in and out of a packet buffer RAM. The host never supplies a full address. It loads a pointer register that holds an 11-bit offset inside a packet, a direction flag, an auto-advance flag and a source selector. It then issues data accesses. The upper address bits are the packet number. That number comes either from the head of the receive queue or from a packet-number register that the host writes, depending on the selector.

Inside a packet, the first word holds a status word and the second holds an 11-bit byte count. Frame data starts at byte 4. The final word carries a control byte, where bit 5 flags an odd length and bit 4 asks for CRC append on transmit; the last data byte of an odd frame shares that word. The port treats all of these as ordinary data. Software walks the layout with the pointer.

When the direction flag marks reads, the port fetches the addressed word from RAM ahead of any request. A host read then completes in the cycle it is offered. Data accesses use a valid/ready handshake. The host holds `acc_valid` and its qualifiers steady until it sees `acc_ready`. An access is taken in a cycle where both are high. For a read, the result appears on `rd_data`, qualified by `rd_valid`, in that same cycle. A write reaches the RAM port in that same cycle. Reads stall while the addressed word is not yet buffered. Writes stall only while a fetch is in flight.

Top module: `pkt_access_port`

## Requirements
- R1: After reset the pointer reads back as zero, the RAM write strobe is low and a read request is not accepted.
- R2: A pointer write stores bit 15 (take packet number from receive queue head), bit 14 (auto-advance), bit 13 (read direction) and bits 10:0 (offset). A readback returns those bits with bits 12:11 as zero.
- R3: The RAM word address is the packet number followed by offset bits 10:1. The packet number is `rxq_head` when pointer bit 15 is set, otherwise the value last written to the packet-number register.
- R4: With auto-advance set, each accepted access adds 1 (byte) or 2 (word) to the offset. The offset wraps modulo 2048.
- R5: With auto-advance clear, accepted accesses leave the offset unchanged.
- R6: After a pointer write with the read bit set, a read request is not accepted in the first cycle after the write. It is accepted in the second cycle with the RAM word at the new address.
- R7: A byte read returns the low RAM byte for an even offset and the high byte for an odd offset, zero-extended. A word read returns the whole word, with an odd offset aligned down.
- R8: An accepted write drives the RAM write strobe in the same cycle. A word write has byte enables 2'b11. A byte write enables 2'b01 at an even offset and 2'b10 at an odd offset, with the byte copied onto both lanes.
- R9: While the pointer read bit is clear, read requests are never accepted.
- R10: If the selected packet number changes after a word has been buffered, the next read returns the word from the new packet.
- R11: A write is not accepted while a RAM fetch is in flight.
- R12: Consecutive byte reads within one word, with auto-advance set, are each accepted in the cycle they are offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxq_head | input | PNUM_W | Packet number at the head of the receive queue |
| pnr_wr | input | 1 | Write strobe for the packet-number register |
| pnr_wdata | input | PNUM_W | Packet-number write value |
| ptr_wr | input | 1 | Write strobe for the pointer register |
| ptr_wdata | input | 16 | Pointer write value |
| ptr_q | output | 16 | Pointer readback |
| acc_valid | input | 1 | Data access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| acc_wdata | input | 16 | Write data (byte in bits 7:0) |
| acc_ready | output | 1 | Access accepted this cycle when high with acc_valid |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 16 | Read result |
| mem_addr | output | PNUM_W+10 | RAM word address |
| mem_re | output | 1 | RAM read strobe (data one cycle later) |
| mem_we | output | 1 | RAM write strobe |
| mem_be | output | 2 | RAM byte enables |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, one cycle after mem_re |

## Verification
A pointer write is taken at one edge. The fetch it starts leaves on the RAM port in the next cycle, and its data is usable right after the following edge. The bench therefore samples `acc_ready` low half a cycle after the first edge and high half a cycle after the second. Read data, write strobes and byte enables are combinational in the accepting cycle, so they are sampled one time step after the inputs settle and before the accepting edge. Offsets are read back through `ptr_q` after the accepting edge.

// File: rtl/pkt_access_pkg.sv
package pkt_access_pkg;
  localparam int PTR_W     = 16;
  localparam int OFS_W     = 11;
  localparam int BIT_RXSEL = 15;
  localparam int BIT_AINC  = 14;
  localparam int BIT_READ  = 13;

  typedef struct packed {
    logic             rx_sel;
    logic             auto_inc;
    logic             rd_mode;
    logic [OFS_W-1:0] ofs;
  } ptr_t;
endpackage

// File: rtl/pkt_ptr_reg.sv
module pkt_ptr_reg
  import pkt_access_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_wr,
  input  logic [PTR_W-1:0] ptr_wdata,
  input  logic             adv,
  input  logic             adv_word,
  output ptr_t             ptr
);
  logic [OFS_W-1:0] step;

  assign step = adv_word ? OFS_W'(2) : OFS_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ptr_wr) begin
      ptr.rx_sel   <= ptr_wdata[BIT_RXSEL];
      ptr.auto_inc <= ptr_wdata[BIT_AINC];
      ptr.rd_mode  <= ptr_wdata[BIT_READ];
      ptr.ofs      <= ptr_wdata[OFS_W-1:0];
    end else if (adv && ptr.auto_inc) begin
      ptr.ofs <= ptr.ofs + step;
    end
  end

  // R4: offset moves by the access width, modulo 2048
  assert_ofs_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ptr_wr && ptr.auto_inc) |=> ptr.ofs == $past(ptr.ofs) + $past(step));

  // R5: no advance without the auto-advance flag
  assert_ofs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ptr_wr && !ptr.auto_inc) |=> $stable(ptr.ofs));
endmodule

// File: rtl/pkt_addr_sel.sv
module pkt_addr_sel
  import pkt_access_pkg::*;
#(
  parameter int PNUM_W = 6,
  localparam int AW    = PNUM_W + OFS_W - 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pnr_wr,
  input  logic [PNUM_W-1:0] pnr_wdata,
  input  logic [PNUM_W-1:0] rxq_head,
  input  logic              rx_sel,
  input  logic [OFS_W-1:0]  ofs,
  output logic [AW-1:0]     waddr
);
  logic [PNUM_W-1:0] pnr_q;
  logic [PNUM_W-1:0] pnum;

  always_ff @(posedge clk) begin
    if (!rst_n)      pnr_q <= '0;
    else if (pnr_wr) pnr_q <= pnr_wdata;
  end

  assign pnum  = rx_sel ? rxq_head : pnr_q;
  assign waddr = {pnum, ofs[OFS_W-1:1]};
endmodule

// File: rtl/pkt_prefetch.sv
module pkt_prefetch #(
  parameter int AW = 16,
  parameter int DW = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_mode,
  input  logic [AW-1:0] cur_waddr,
  input  logic          ptr_wr,
  input  logic          wr_req,
  input  logic          wr_acc,
  input  logic [DW-1:0] mem_rdata,
  output logic          fetch_go,
  output logic          fl_busy,
  output logic          data_ok,
  output logic [DW-1:0] data_word
);
  logic          pf_valid, fl_valid;
  logic [AW-1:0] pf_addr, fl_addr;
  logic [DW-1:0] pf_data;
  logic          pf_hit, fl_hit;

  assign pf_hit    = pf_valid && (pf_addr == cur_waddr);
  assign fl_hit    = fl_valid && (fl_addr == cur_waddr);
  assign data_ok   = pf_hit || fl_hit;
  assign data_word = fl_hit ? mem_rdata : pf_data;
  assign fetch_go  = rd_mode && !data_ok && !wr_req && !ptr_wr;
  assign fl_busy   = fl_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fl_valid <= 1'b0;
      fl_addr  <= '0;
      pf_valid <= 1'b0;
      pf_addr  <= '0;
      pf_data  <= '0;
    end else begin
      fl_valid <= fetch_go;
      if (fetch_go) fl_addr <= cur_waddr;
      if (ptr_wr || wr_acc) begin
        pf_valid <= 1'b0;
      end else if (fl_valid) begin
        pf_valid <= 1'b1;
        pf_addr  <= fl_addr;
        pf_data  <= mem_rdata;
      end
    end
  end
endmodule

// File: rtl/pkt_access_port.sv
module pkt_access_port
  import pkt_access_pkg::*;
#(
  parameter int PNUM_W = 6,
  localparam int AW    = PNUM_W + OFS_W - 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PNUM_W-1:0] rxq_head,
  input  logic              pnr_wr,
  input  logic [PNUM_W-1:0] pnr_wdata,
  input  logic              ptr_wr,
  input  logic [PTR_W-1:0]  ptr_wdata,
  output logic [PTR_W-1:0]  ptr_q,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_word,
  input  logic [15:0]       acc_wdata,
  output logic              acc_ready,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata
);
  ptr_t          ptr;
  logic [AW-1:0] cur_waddr;
  logic          fetch_go, fl_busy, data_ok;
  logic [15:0]   data_word;
  logic          acc_fire;

  assign acc_ready = acc_write ? !fl_busy : (ptr.rd_mode && data_ok);
  assign acc_fire  = acc_valid && acc_ready;

  pkt_ptr_reg u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr_wr    (ptr_wr),
    .ptr_wdata (ptr_wdata),
    .adv       (acc_fire),
    .adv_word  (acc_word),
    .ptr       (ptr)
  );

  pkt_addr_sel #(.PNUM_W(PNUM_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .pnr_wr    (pnr_wr),
    .pnr_wdata (pnr_wdata),
    .rxq_head  (rxq_head),
    .rx_sel    (ptr.rx_sel),
    .ofs       (ptr.ofs),
    .waddr     (cur_waddr)
  );

  pkt_prefetch #(.AW(AW), .DW(16)) u_pf (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_mode   (ptr.rd_mode),
    .cur_waddr (cur_waddr),
    .ptr_wr    (ptr_wr),
    .wr_req    (acc_valid && acc_write),
    .wr_acc    (acc_fire && acc_write),
    .mem_rdata (mem_rdata),
    .fetch_go  (fetch_go),
    .fl_busy   (fl_busy),
    .data_ok   (data_ok),
    .data_word (data_word)
  );

  assign ptr_q = {ptr.rx_sel, ptr.auto_inc, ptr.rd_mode, 2'b00, ptr.ofs};

  assign rd_valid = acc_fire && !acc_write;
  assign rd_data  = acc_word  ? data_word :
                    ptr.ofs[0] ? {8'h00, data_word[15:8]} : {8'h00, data_word[7:0]};

  assign mem_addr  = cur_waddr;
  assign mem_re    = fetch_go;
  assign mem_we    = acc_fire && acc_write;
  assign mem_be    = acc_word ? 2'b11 : (ptr.ofs[0] ? 2'b10 : 2'b01);
  assign mem_wdata = acc_word ? acc_wdata : {2{acc_wdata[7:0]}};

  // R11: the RAM port never writes while a fetch is returning
  assert_no_wr_in_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !fl_busy);

  // R9: reads only complete in read direction
  assert_rd_needs_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ptr.rd_mode);

  // R8: a byte write touches exactly one lane
  assert_byte_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !acc_word) |-> $countones(mem_be) == 1);

  // R6: no read is taken in the cycle right after a pointer write
  assert_ptr_wr_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> !rd_valid);
endmodule

// File: tb/pkt_access_port_bench.sv
module pkt_access_port_bench;
  localparam int PNUM_W = 6;
  localparam int AW     = PNUM_W + 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [PNUM_W-1:0] rxq_head = '0;
  logic              pnr_wr = 1'b0;
  logic [PNUM_W-1:0] pnr_wdata = '0;
  logic              ptr_wr = 1'b0;
  logic [15:0]       ptr_wdata = '0;
  logic [15:0]       ptr_q;
  logic              acc_valid = 1'b0;
  logic              acc_write = 1'b0;
  logic              acc_word = 1'b0;
  logic [15:0]       acc_wdata = '0;
  logic              acc_ready, rd_valid;
  logic [15:0]       rd_data;
  logic [AW-1:0]     mem_addr;
  logic              mem_re, mem_we;
  logic [1:0]        mem_be;
  logic [15:0]       mem_wdata;
  logic [15:0]       mem_rdata = '0;

  int tests = 0;
  int fails = 0;

  logic          l_ok, l_rv, l_we;
  logic [15:0]   l_rd, l_wd;
  logic [1:0]    l_be;
  logic [AW-1:0] l_addr;

  always #4 clk = ~clk;

  pkt_access_port #(.PNUM_W(PNUM_W)) u_pkt_access_port (
    .clk(clk), .rst_n(rst_n), .rxq_head(rxq_head), .pnr_wr(pnr_wr),
    .pnr_wdata(pnr_wdata), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
    .ptr_q(ptr_q), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_word(acc_word), .acc_wdata(acc_wdata), .acc_ready(acc_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] fmem(input logic [AW-1:0] a);
    return 16'(a) ^ 16'h3C5A;
  endfunction

  always_ff @(posedge clk) if (mem_re) mem_rdata <= fmem(mem_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_ptr(input logic [15:0] v);
    @(negedge clk); ptr_wr = 1'b1; ptr_wdata = v;
    @(negedge clk); ptr_wr = 1'b0;
  endtask

  task automatic set_pnr(input logic [PNUM_W-1:0] v);
    @(negedge clk); pnr_wr = 1'b1; pnr_wdata = v;
    @(negedge clk); pnr_wr = 1'b0;
  endtask

  task automatic access(input logic w, input logic wd, input logic [15:0] d);
    int n = 0;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_word = wd; acc_wdata = d;
    #1;
    while (!acc_ready && n < 20) begin @(negedge clk); #1; n++; end
    l_ok = acc_ready; l_rv = rd_valid; l_rd = rd_data;
    l_we = mem_we; l_be = mem_be; l_wd = mem_wdata; l_addr = mem_addr;
    @(negedge clk); acc_valid = 1'b0;
  endtask

  function automatic logic [AW-1:0] wa(input logic [5:0] p, input logic [10:0] o);
    return {p, o[10:1]};
  endfunction

  task automatic t_reset;
    @(negedge clk); acc_valid = 1'b1; acc_write = 1'b0; #1;
    chk("R1 ptr", 32'(ptr_q), 32'h0);
    chk("R1 we", 32'(mem_we), 32'h0);
    chk("R1 ready", 32'(acc_ready), 32'h0);
    acc_valid = 1'b0;
  endtask

  task automatic t_fields;
    set_ptr(16'hFFFF); #1;
    chk("R2 readback", 32'(ptr_q), 32'hE7FF);
    set_ptr(16'h0123); #1;
    chk("R2 offset", 32'(ptr_q), 32'h0123);
  endtask

  task automatic t_select;
    set_pnr(6'd5); rxq_head = 6'd9;
    set_ptr(16'h0123); #1;
    chk("R3 pnr", 32'(mem_addr), 32'(wa(6'd5, 11'h123)));
    set_ptr(16'h8123); #1;
    chk("R3 rxhead", 32'(mem_addr), 32'(wa(6'd9, 11'h123)));
  endtask

  task automatic t_prefetch;
    set_pnr(6'd3);
    set_ptr(16'h2010);
    acc_valid = 1'b1; acc_write = 1'b0; acc_word = 1'b1; #1;
    chk("R6 not yet", 32'(acc_ready), 32'h0);
    @(negedge clk); #1;
    chk("R6 ready", 32'(acc_ready), 32'h1);
    chk("R6 data", 32'(rd_data), 32'(fmem(wa(6'd3, 11'h010))));
    @(negedge clk); acc_valid = 1'b0;
  endtask

  task automatic t_byte_reads;
    set_pnr(6'd3);
    set_ptr(16'h6010);
    access(1'b0, 1'b0, 16'h0);
    chk("R7 even byte", 32'(l_rd), 32'(fmem(wa(6'd3, 11'h010)) & 16'h00FF));
    chk("R4 byte step", 32'(ptr_q[10:0]), 32'h011);
    @(negedge clk); acc_valid = 1'b1; acc_write = 1'b0; acc_word = 1'b0; #1;
    chk("R12 no bubble", 32'(acc_ready), 32'h1);
    chk("R7 odd byte", 32'(rd_data), 32'(fmem(wa(6'd3, 11'h010)) >> 8));
    @(negedge clk); acc_valid = 1'b0;
    set_ptr(16'h6021);
    access(1'b0, 1'b1, 16'h0);
    chk("R7 odd word", 32'(l_rd), 32'(fmem(wa(6'd3, 11'h020))));
    chk("R4 word step", 32'(ptr_q[10:0]), 32'h023);
  endtask

  task automatic t_wrap;
    set_ptr(16'h47FF);
    access(1'b1, 1'b1, 16'hBEEF);
    chk("R4 word wrap", 32'(ptr_q[10:0]), 32'h001);
    set_ptr(16'h47FF);
    access(1'b1, 1'b0, 16'h0012);
    chk("R4 byte wrap", 32'(ptr_q[10:0]), 32'h000);
  endtask

  task automatic t_noinc;
    set_pnr(6'd7);
    set_ptr(16'h2044);
    access(1'b0, 1'b1, 16'h0);
    chk("R5 data", 32'(l_rd), 32'(fmem(wa(6'd7, 11'h044))));
    access(1'b0, 1'b1, 16'h0);
    chk("R5 hold", 32'(ptr_q[10:0]), 32'h044);
  endtask

  task automatic t_writes;
    set_pnr(6'd2);
    set_ptr(16'h4031);
    access(1'b1, 1'b0, 16'h00A7);
    chk("R8 we", 32'(l_we), 32'h1);
    chk("R8 odd be", 32'(l_be), 32'h2);
    chk("R8 byte data", 32'(l_wd), 32'hA7A7);
    chk("R8 addr", 32'(l_addr), 32'(wa(6'd2, 11'h031)));
    access(1'b1, 1'b0, 16'h0055);
    chk("R8 even be", 32'(l_be), 32'h1);
    access(1'b1, 1'b1, 16'h1234);
    chk("R8 word be", 32'(l_be), 32'h3);
    chk("R8 word data", 32'(l_wd), 32'h1234);
  endtask

  task automatic t_no_read_mode;
    set_ptr(16'h4010);
    @(negedge clk); acc_valid = 1'b1; acc_write = 1'b0; acc_word = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R9 ready", 32'(acc_ready), 32'h0);
    chk("R9 rd_valid", 32'(rd_valid), 32'h0);
    acc_valid = 1'b0;
  endtask

  task automatic t_pkt_change;
    rxq_head = 6'd2;
    set_ptr(16'hA050);
    access(1'b0, 1'b1, 16'h0);
    chk("R10 first", 32'(l_rd), 32'(fmem(wa(6'd2, 11'h050))));
    @(negedge clk); rxq_head = 6'd4;
    access(1'b0, 1'b1, 16'h0);
    chk("R10 new pkt", 32'(l_rd), 32'(fmem(wa(6'd4, 11'h050))));
  endtask

  task automatic t_wr_stall;
    set_pnr(6'd1);
    set_ptr(16'h2060);
    acc_valid = 1'b1; acc_write = 1'b1; acc_word = 1'b1; acc_wdata = 16'h0;
    #1;
    chk("R11 issue slot", 32'(mem_re), 32'h0);
    acc_valid = 1'b0;
    @(negedge clk); #1;
    acc_valid = 1'b1; #1;
    chk("R11 stall", 32'(acc_ready), 32'h0);
    @(negedge clk); #1;
    chk("R11 resume", 32'(acc_ready), 32'h1);
    acc_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_fields();
    t_select();
    t_prefetch();
    t_byte_reads();
    t_wrap();
    t_noinc();
    t_writes();
    t_no_read_mode();
    t_pkt_change();
    t_wr_stall();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule